// File: doc/BRIEF.md
# Gated Clock Selector with Halving Bank

This block picks one of two incoming clocks, opens or closes a gate on the picked clock under an enable input, and fans the result out to two banks of true/complement output pairs. Bank A carries the gated clock at its own rate. Bank B carries the gated clock halved by a toggle stage that shares the same gate. A master reset forces every true output low and every complement output high. It also clears the toggle stage.

The enable may change at any moment with respect to the picked clock. A small state machine samples it on a rising edge of the picked clock. The gate flop then takes up the decision on the next falling edge, so the gate can only open or close while the picked clock is low, and no pulse is ever cut short. The machine has three states. `GS_RESET` is held while reset is high. On the first rising edge after release it moves to `GS_OPEN` if enable is high and to `GS_CLOSED` if not. `GS_CLOSED` moves to `GS_OPEN` when enable is high, and `GS_OPEN` moves to `GS_CLOSED` when enable is low. The clock choice is static configuration and is set while the block is held in reset or while it is idle.

Top module: `clkdiv_gate_top`

## Requirements
- R1: With `sel_sec` = 1 the outputs are derived from `clk_sec`; with `sel_sec` = 0 they are derived from `clk_pri`.
- R2: A change of `en` reaches the outputs only after a rising edge and then a falling edge of the picked clock. A pulse already under way therefore completes in full, and a new first pulse starts at a rising edge.
- R3: While the gate is closed, every true output is 0 and every complement output is 1.
- R4: While `mrst` is 1, every true output is 0 and every complement output is 1, whatever `en` and `sel_sec` are. This takes effect without waiting for a clock edge.
- R5: With the gate open, every bank A true output equals the picked clock (non-inverting), and all bank A pairs carry the same level.
- R6: With the gate open, every bank B true output toggles on each rising edge of the picked clock. Its high time equals one picked-clock period, so it runs at half the bank A rate with a 50% duty cycle.
- R7: Every complement output is the logical inverse of its true output at all times.
- R8: The halving stage holds its state while the gate is closed, and bank B is held low during that time.
- R9: After `mrst` falls, the first bank A pulse and the first bank B rising edge both come at the second rising edge of the picked clock, and the first bank B pulse is a full period wide.
- R10: When `en` is toggled at arbitrary times, no output pulse, high or low, is shorter than half a period of the picked clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock, picked when `sel_sec` is 0 |
| clk_sec | input | 1 | Secondary clock, picked when `sel_sec` is 1 |
| sel_sec | input | 1 | Clock choice, static while running |
| en | input | 1 | Output enable, may change asynchronously |
| mrst | input | 1 | Master reset, active high, asynchronous assert |
| qa_p | output | A_PAIRS | Bank A true outputs, divide by one |
| qa_n | output | A_PAIRS | Bank A complement outputs |
| qb_p | output | B_PAIRS | Bank B true outputs, divide by two |
| qb_n | output | B_PAIRS | Bank B complement outputs |

## Verification
The bench drops and raises the enable in the middle of a high phase. A design that gates on the enable directly would clip that pulse or start a partial one, so the bench checks that the running pulse completes and that the first new pulse comes one full cycle later. It releases reset while the clock is low and checks the exact cycle of the first bank A and bank B edges. A toggle stage that was not cleared, or a release that was not aligned, would show a shifted or narrow first bank B pulse. It then toggles the enable at irregular offsets while timing every edge, and it counts edges to confirm the 2:1 rate on both input clocks. A gate flop clocked on the wrong edge would produce runt pulses, and a wrong mux would produce the wrong period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Gate-control states, advanced on the rising edge of the picked clock
    typedef enum logic [1:0] {
        GS_RESET  = 2'd0,
        GS_CLOSED = 2'd1,
        GS_OPEN   = 2'd2
    } gate_state_t;

endpackage

// File: rtl/clkdiv_gate_fsm.sv
module clkdiv_gate_fsm
    import clkdiv_pkg::*;
(
    input  logic src_clk,
    input  logic rst,
    input  logic en,
    output logic gate_q
);

    gate_state_t state_q;
    gate_state_t state_d;

    // State register: decision taken on the rising edge
    always_ff @(posedge src_clk or posedge rst) begin
        if (rst) state_q <= GS_RESET;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RESET:  state_d = en ? GS_OPEN : GS_CLOSED;
            GS_CLOSED: if (en)  state_d = GS_OPEN;
            GS_OPEN:   if (!en) state_d = GS_CLOSED;
            default:   state_d = GS_RESET;
        endcase
    end

    // Output process: the gate moves only on the falling edge, while the clock is low
    always_ff @(negedge src_clk or posedge rst) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= (state_q == GS_OPEN);
    end

    // R2
    gate_open_needs_en_chk: assert property (@(posedge src_clk) disable iff (rst)
        $rose(gate_q) |-> $past(en));

    // R2
    gate_close_needs_no_en_chk: assert property (@(posedge src_clk) disable iff (rst)
        $fell(gate_q) |-> !$past(en));

endmodule

// File: rtl/clkdiv_toggle.sv
module clkdiv_toggle (
    input  logic gclk,
    input  logic rst,
    output logic q
);

    // Halving stage: flips on every rising edge of the gated clock
    always_ff @(posedge gclk or posedge rst) begin
        if (rst) q <= 1'b0;
        else     q <= ~q;
    end

endmodule

// File: rtl/clkdiv_outbank.sv
module clkdiv_outbank #(
    parameter int PAIRS = 2
) (
    input  logic             level,
    output logic [PAIRS-1:0] p,
    output logic [PAIRS-1:0] n
);

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign p[i] = level;
        assign n[i] = ~level;
    end

endmodule

// File: rtl/clkdiv_gate_top.sv
module clkdiv_gate_top #(
    parameter int A_PAIRS = 2,
    parameter int B_PAIRS = 2
) (
    input  logic               clk_pri,
    input  logic               clk_sec,
    input  logic               sel_sec,
    input  logic               en,
    input  logic               mrst,
    output logic [A_PAIRS-1:0] qa_p,
    output logic [A_PAIRS-1:0] qa_n,
    output logic [B_PAIRS-1:0] qb_p,
    output logic [B_PAIRS-1:0] qb_n
);

    logic src_clk;
    logic gate_q;
    logic gclk;
    logic div_q;
    logic a_lvl;
    logic b_lvl;

    // Static clock choice
    assign src_clk = sel_sec ? clk_sec : clk_pri;

    clkdiv_gate_fsm u_fsm (
        .src_clk (src_clk),
        .rst     (mrst),
        .en      (en),
        .gate_q  (gate_q)
    );

    // Gate only changes while src_clk is low, so the AND cannot glitch
    assign gclk = src_clk & gate_q;

    clkdiv_toggle u_div (
        .gclk (gclk),
        .rst  (mrst),
        .q    (div_q)
    );

    assign a_lvl = gclk;
    assign b_lvl = div_q & gate_q;

    clkdiv_outbank #(.PAIRS(A_PAIRS)) u_bank_a (
        .level (a_lvl),
        .p     (qa_p),
        .n     (qa_n)
    );

    clkdiv_outbank #(.PAIRS(B_PAIRS)) u_bank_b (
        .level (b_lvl),
        .p     (qb_p),
        .n     (qb_n)
    );

    // R6
    div_toggles_when_open_chk: assert property (@(posedge src_clk) disable iff (mrst)
        $past(gate_q) |-> (div_q != $past(div_q)));

    // R8
    div_holds_when_closed_chk: assert property (@(posedge src_clk) disable iff (mrst)
        !$past(gate_q) |-> $stable(div_q));

endmodule

// File: tb/clkdiv_gate_top_tb.sv
`timescale 1ns/1ps
module clkdiv_gate_top_tb;

    localparam int  CLK_PERIOD = 10;
    localparam int  SEC_PERIOD = 14;
    localparam real TOL        = 0.01;

    logic clk_pri = 1'b0;
    logic clk_sec = 1'b0;
    logic sel_sec = 1'b0;
    logic en      = 1'b1;
    logic mrst    = 1'b1;
    logic [1:0] qa_p, qa_n, qb_p, qb_n;

    int checks = 0;
    int errors = 0;

    clkdiv_gate_top u_dut (
        .clk_pri (clk_pri),
        .clk_sec (clk_sec),
        .sel_sec (sel_sec),
        .en      (en),
        .mrst    (mrst),
        .qa_p    (qa_p),
        .qa_n    (qa_n),
        .qb_p    (qb_p),
        .qb_n    (qb_n)
    );

    always #(CLK_PERIOD/2.0) clk_pri = ~clk_pri;
    always #(SEC_PERIOD/2.0) clk_sec = ~clk_sec;

    // ---------------- pulse monitors ----------------
    bit  mon_on = 1'b0;
    bit  a_valid = 1'b0, b_valid = 1'b0;
    real a_last = 0.0, b_last = 0.0, b_rise = 0.0, b_hi = 0.0;
    int  short_cnt = 0;
    int  cnt_a = 0, cnt_b = 0;

    function automatic real half_per();
        return sel_sec ? SEC_PERIOD / 2.0 : CLK_PERIOD / 2.0;
    endfunction

    always @(qa_p[0]) begin
        if (mon_on && a_valid && ($realtime - a_last) < half_per() - TOL) short_cnt++;
        a_last  = $realtime;
        a_valid = 1'b1;
        if (qa_p[0] === 1'b1) cnt_a++;
    end

    always @(qb_p[0]) begin
        if (mon_on && b_valid && ($realtime - b_last) < half_per() - TOL) short_cnt++;
        b_last  = $realtime;
        b_valid = 1'b1;
        if (qb_p[0] === 1'b1) begin
            cnt_b++;
            b_rise = $realtime;
        end else begin
            b_hi = $realtime - b_rise;
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_real(input string req, input real act, input real exp);
        checks++;
        if (act < exp - TOL || act > exp + TOL) begin
            errors++;
            $display("FAIL %s actual=%0f expected=%0f at %0t", req, act, exp, $time);
        end
    endtask

    // All pairs idle: true low, complement high
    task automatic chk_idle(input string req);
        chk({req, " qa_p"}, qa_p, 2'b00);
        chk({req, " qa_n"}, qa_n, 2'b11);
        chk({req, " qb_p"}, qb_p, 2'b00);
        chk({req, " qb_n"}, qb_n, 2'b11);
    endtask

    task automatic src_rise();
        if (sel_sec) @(posedge clk_sec); else @(posedge clk_pri);
        #2;
    endtask

    task automatic src_fall();
        if (sel_sec) @(negedge clk_sec); else @(negedge clk_pri);
        #2;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_hold();
        for (int i = 0; i < 3; i++) src_rise();
        chk_idle("R4 reset en=1 sel=0");
        sel_sec = 1'b1;
        for (int i = 0; i < 2; i++) src_rise();
        chk_idle("R4 reset en=1 sel=1");
        sel_sec = 1'b0;
        src_rise();
    endtask

    task automatic t_release_first_pulse();
        src_fall();
        mrst = 1'b0;
        src_rise();
        chk("R9 first edge A low", {qa_p[0], qb_p[0]}, 2'b00);
        src_rise();
        chk("R9 second edge A,B high", {qa_p[0], qb_p[0]}, 2'b11);
        src_rise();
        chk("R9 B falls after full period", {qa_p[0], qb_p[0]}, 2'b10);
        src_rise();
        chk("R6 B rises again", {qa_p[0], qb_p[0]}, 2'b11);
    endtask

    task automatic t_follow(input string tag, input int per);
        int bad_hi = 0, bad_lo = 0, bad_cmp = 0;
        src_rise();
        cnt_a = 0;
        cnt_b = 0;
        for (int i = 0; i < 20; i++) begin
            src_fall();
            if (qa_p !== 2'b00) bad_lo++;
            if (qa_n !== ~qa_p || qb_n !== ~qb_p) bad_cmp++;
            src_rise();
            if (qa_p !== 2'b11) bad_hi++;
            if (qa_n !== ~qa_p || qb_n !== ~qb_p) bad_cmp++;
        end
        chk_int({tag, " R5 A high with clock"}, bad_hi, 0);
        chk_int({tag, " R5 A low with clock"}, bad_lo, 0);
        chk_int({tag, " R7 complement mismatches"}, bad_cmp, 0);
        chk_int({tag, " R5 A rising edges"}, cnt_a, 20);
        chk_int({tag, " R6 B rising edges"}, cnt_b, 10);
        chk_real({tag, " R6 B high time"}, b_hi, real'(per));
    endtask

    task automatic t_disable();
        int bad = 0;
        src_rise();
        en = 1'b0;
        src_rise();
        chk("R2 running pulse completes", qa_p, 2'b11);
        src_rise();
        chk_idle("R3 gate closed");
        for (int i = 0; i < 6; i++) begin
            src_rise();
            if (qb_p !== 2'b00 || qa_p !== 2'b00 || qb_n !== 2'b11) bad++;
        end
        chk_int("R8 B held low while closed", bad, 0);
    endtask

    task automatic t_enable();
        src_rise();
        en = 1'b1;
        src_rise();
        chk("R2 no pulse before fall edge", qa_p, 2'b00);
        src_rise();
        chk("R2 first pulse after reopen", qa_p, 2'b11);
    endtask

    task automatic t_async_reset();
        src_rise();
        mrst = 1'b1;
        #1;
        chk_idle("R4 async reset mid pulse");
    endtask

    task automatic t_secondary();
        sel_sec = 1'b1;
        src_fall();
        mrst = 1'b0;
        src_rise();
        src_rise();
        chk("R1 secondary clock drives A", qa_p, 2'b11);
        src_fall();
        chk("R1 secondary low phase", qa_p, 2'b00);
        t_follow("sec", SEC_PERIOD);
    endtask

    task automatic t_enable_storm();
        src_rise();
        a_valid   = 1'b0;
        b_valid   = 1'b0;
        short_cnt = 0;
        mon_on    = 1'b1;
        for (int i = 0; i < 40; i++) begin
            #(1.3 + ((i * 7) % 11) * 1.9);
            en = ~en;
        end
        en = 1'b1;
        for (int i = 0; i < 6; i++) src_rise();
        mon_on = 1'b0;
        chk_int("R10 short pulses during enable toggling", short_cnt, 0);
    endtask

    // ---------------- sequence ----------------
    bit done = 1'b0;

    initial begin
        t_reset_hold();
        t_release_first_pulse();
        t_follow("pri", CLK_PERIOD);
        t_disable();
        t_enable();
        t_async_reset();
        t_secondary();
        t_enable_storm();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule